// File: doc/BRIEF.md
# Codec Control-Port Serial Writer

This block sends register writes to an audio codec over a three-wire, write-only serial control port. A client offers a register address and a data value on a valid/ready request interface. The block packs them into one frame word, with the address above the data field, and shifts the word out most significant bit first. The port has an active-low select, a bit clock and a data line. A direction line is driven to write mode when the first frame starts. Each frame ends with the clock going low at the moment select is released, followed by one extra rising clock edge. Every level on the port is held for a programmable number of system clocks, so the timing the device needs, about 1 µs per step, is met.

The block keeps a shadow copy of each register it writes. Other logic reads the last written value through a combinational port, with no traffic on the serial bus. A request can carry a no-cache flag. Such a write goes out on the wire but leaves the shadow copy as it was. Only one frame is in flight at a time, and the request interface stays not-ready until the trailing clock step has finished.

Top module: `ctlport_writer`

## Requirements
- R1: After reset, select is high, the bit clock is high, data is low, the direction line is low (idle), ready is high and every shadow entry reads zero.
- R2: The frame is `{address, data}` (ADDR_W + DATA_W bits, 16 by default), sent most significant bit first. Each bit is valid on the rising bit-clock edge, and exactly FRAME_W rising edges occur while select is low.
- R3: On acceptance, select goes low and the direction line goes high (1 = write) in the same cycle. The bit clock is still high at that point and stays high for one phase.
- R4: Every bit takes three phases in order: the clock falls, then the data bit is placed, then the clock rises. Each phase lasts exactly HOLD_CYC system clocks.
- R5: After the last bit, the clock falls and select rises in the same cycle. One phase later the clock rises once more. No other rising edge occurs while select is high before ready returns.
- R6: Ready drops in the cycle after a request is accepted and stays low for exactly (3·FRAME_W+3)·HOLD_CYC cycles.
- R7: A normal write to an address below DEPTH sets that shadow entry to the written data from the cycle after acceptance.
- R8: A no-cache write sends its frame but leaves every shadow entry unchanged.
- R9: A write to an address at or above DEPTH sends its frame but changes no shadow entry, including the entry that shares its low index bits.
- R10: A request that is valid while the block is busy is not accepted and has no effect on the port or on the shadow.
- R11: The data line changes only while the bit clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Codec register address |
| req_data | input | DATA_W | Register value |
| req_nocache | input | 1 | 1 = transmit without updating the shadow |
| port_sel_n | output | 1 | Active-low device select |
| port_clk | output | 1 | Serial bit clock |
| port_data | output | 1 | Serial data, MSB first |
| port_dir_wr | output | 1 | Direction line, 1 = write |
| shd_raddr | input | $clog2(DEPTH) | Shadow read index |
| shd_rdata | output | DATA_W | Shadow contents at shd_raddr |

## Verification
The bench builds the block with HOLD_CYC = 3. Each phase then lasts three cycles, so the model can check every phase boundary and the hold time between them, and a full frame still takes only 153 cycles. DEPTH stays at 32 while the address is 7 bits wide. This makes out-of-range addresses reachable, including one whose low bits alias a live entry, so the exclusion of R9 can be tested. A frame at the top shadow index and requests held valid through a busy frame cover the remaining edge cases.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_CLKLO,
      ST_DAT,
      ST_CLKHI,
      ST_END,
      ST_TAIL
   } wr_state_t;
endpackage

// File: rtl/ctlport_tick.sv
module ctlport_tick #(
   parameter int HOLD_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("ctlport_tick: HOLD_CYC must be at least 1");
      end else if (HOLD_CYC == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int CNT_W = $clog2(HOLD_CYC);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);
         logic [CNT_W-1:0] cnt;
         assign tick = run && (cnt == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run || tick)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ctlport_shadow.sv
module ctlport_shadow #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 9,
   parameter int DEPTH  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [$clog2(DEPTH)-1:0]   rd_addr,
   output logic [DATA_W-1:0]          rd_data
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [DATA_W-1:0] entry [DEPTH];
   logic              in_range;

   generate
      if (DEPTH < 2 || DEPTH > (1 << ADDR_W) || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("ctlport_shadow: DEPTH must be a power of two in 2..2**ADDR_W");
      end
      if (DEPTH < (1 << ADDR_W)) begin : g_partial
         assign in_range = (wr_addr[ADDR_W-1:IDX_W] == '0);
      end else begin : g_full
         assign in_range = 1'b1;
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               entry[i] <= '0;
            else if (wr_en && in_range && (wr_addr[IDX_W-1:0] == IDX_W'(i)))
               entry[i] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = entry[rd_addr];
endmodule

// File: rtl/ctlport_sequencer.sv
module ctlport_sequencer
   import ctlport_pkg::*;
#(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   input  logic               tick,
   output logic               busy,
   output logic               sel_n,
   output logic               sclk,
   output logic               sdata,
   output logic               dir_wr
);
   localparam int BC_W = $clog2(FRAME_W);

   wr_state_t          state;
   logic [FRAME_W-1:0] shreg;
   logic [BC_W-1:0]    bits_left;

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         bits_left <= '0;
         sel_n     <= 1'b1;
         sclk      <= 1'b1;
         sdata     <= 1'b0;
         dir_wr    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               shreg     <= frame;
               bits_left <= BC_W'(FRAME_W - 1);
               sel_n     <= 1'b0;
               dir_wr    <= 1'b1;
               state     <= ST_SEL;
            end
            ST_SEL: if (tick) begin
               sclk  <= 1'b0;
               state <= ST_CLKLO;
            end
            ST_CLKLO: if (tick) begin
               sdata <= shreg[FRAME_W-1];
               state <= ST_DAT;
            end
            ST_DAT: if (tick) begin
               sclk  <= 1'b1;
               state <= ST_CLKHI;
            end
            ST_CLKHI: if (tick) begin
               sclk <= 1'b0;
               if (bits_left == '0) begin
                  sel_n <= 1'b1;
                  state <= ST_END;
               end else begin
                  bits_left <= bits_left - 1'b1;
                  shreg     <= {shreg[FRAME_W-2:0], 1'b0};
                  state     <= ST_CLKLO;
               end
            end
            ST_END: if (tick) begin
               sclk  <= 1'b1;
               state <= ST_TAIL;
            end
            ST_TAIL: if (tick) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ctlport_writer.sv
module ctlport_writer #(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 9,
   parameter int DEPTH    = 32,
   parameter int HOLD_CYC = 100
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_data,
   input  logic                     req_nocache,
   output logic                     port_sel_n,
   output logic                     port_clk,
   output logic                     port_data,
   output logic                     port_dir_wr,
   input  logic [$clog2(DEPTH)-1:0] shd_raddr,
   output logic [DATA_W-1:0]        shd_rdata
);
   localparam int FRAME_W = ADDR_W + DATA_W;

   generate
      if (ADDR_W < 1 || DATA_W < 1 || FRAME_W < 2) begin : g_bad_width
         $error("ctlport_writer: address and data widths must be positive");
      end
   endgenerate

   logic busy, tick, accept;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;

   ctlport_tick #(.HOLD_CYC(HOLD_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
   );

   ctlport_sequencer #(.FRAME_W(FRAME_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .frame({req_addr, req_data}), .tick(tick), .busy(busy),
      .sel_n(port_sel_n), .sclk(port_clk), .sdata(port_data),
      .dir_wr(port_dir_wr)
   );

   ctlport_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(accept && !req_nocache),
      .wr_addr(req_addr), .wr_data(req_data),
      .rd_addr(shd_raddr), .rd_data(shd_rdata)
   );
endmodule

// File: rtl/ctlport_writer_chk.sv
module ctlport_writer_chk #(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 9,
   parameter int DEPTH    = 32,
   parameter int HOLD_CYC = 100
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic [ADDR_W-1:0]        req_addr,
   input logic [DATA_W-1:0]        req_data,
   input logic                     req_nocache,
   input logic                     port_sel_n,
   input logic                     port_clk,
   input logic                     port_data,
   input logic                     port_dir_wr,
   input logic [$clog2(DEPTH)-1:0] shd_raddr,
   input logic [DATA_W-1:0]        shd_rdata
);
   logic acc, hit;
   assign acc = req_valid && req_ready;
   assign hit = (req_addr == ADDR_W'(shd_raddr));

   // R3
   sel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(port_sel_n) |-> (port_clk && port_dir_wr));

   // R5
   sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_sel_n) |-> $fell(port_clk));

   // R6
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !req_ready);

   // R11
   data_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(port_data) |-> !port_clk);

   // R7
   shadow_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_nocache && hit) ##1 $stable(shd_raddr) |-> (shd_rdata == $past(req_data)));

   // R8
   nocache_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_nocache) ##1 $stable(shd_raddr) |-> $stable(shd_rdata));
endmodule

bind ctlport_writer ctlport_writer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .HOLD_CYC(HOLD_CYC)
) u_chk (.*);

// File: tb/sim_ctlport_writer.sv
module sim_ctlport_writer;
   localparam int H  = 3;
   localparam int FW = 16;
   localparam int PH = 3 * FW + 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [6:0] req_addr = '0;
   logic [8:0] req_data = '0;
   logic req_nocache = 1'b0;
   logic port_sel_n, port_clk, port_data, port_dir_wr;
   logic [4:0] shd_raddr = '0;
   logic [8:0] shd_rdata;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   ctlport_writer #(.ADDR_W(7), .DATA_W(9), .DEPTH(32), .HOLD_CYC(H)) u0 (.*);

   // behavioural reference model
   bit         m_busy = 0;
   int         k = 0;
   logic [15:0] m_frame = '0;
   logic        m_last = 1'b0;
   logic        m_dir = 1'b0;
   logic [8:0]  m_shadow [32];
   initial foreach (m_shadow[i]) m_shadow[i] = '0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (m_busy) begin
            k = k + 1;
            if (k == PH * H) begin
               m_busy = 0;
               m_last = m_frame[0];
            end
         end else if (req_valid) begin
            m_busy  = 1;
            k       = 0;
            m_dir   = 1'b1;
            m_frame = {req_addr, req_data};
            if (!req_nocache && req_addr < 7'd32) m_shadow[req_addr[4:0]] = req_data;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   bit sweep = 1;
   logic e_sel, e_clk, e_dat, e_rdy;
   always @(negedge clk) begin
      if (rst_n) begin
         e_rdy = !m_busy; e_sel = 1'b1; e_clk = 1'b1; e_dat = m_last;
         if (m_busy) begin
            int p;
            p = k / H;
            if (p == 0) begin
               e_sel = 1'b0;
            end else if (p <= 3 * FW) begin
               int q, b, s;
               q = p - 1; b = q / 3; s = q % 3;
               e_sel = 1'b0;
               e_clk = (s == 2);
               if (s == 0) e_dat = (b == 0) ? m_last : m_frame[16 - b];
               else        e_dat = m_frame[15 - b];
            end else begin
               e_clk = (p == 3 * FW + 2);
               e_dat = m_frame[0];
            end
         end
         chk(port_sel_n == e_sel, "R3", "select", port_sel_n, e_sel);
         chk(port_clk == e_clk, "R4", "bit clock", port_clk, e_clk);
         chk(port_data == e_dat, "R2", "data", port_data, e_dat);
         chk(req_ready == e_rdy, "R6", "ready", req_ready, e_rdy);
         chk(port_dir_wr == m_dir, "R3", "direction", port_dir_wr, m_dir);
         chk(shd_rdata == m_shadow[shd_raddr], "R7", "shadow read", shd_rdata,
             m_shadow[shd_raddr]);
         if (sweep) shd_raddr <= shd_raddr + 1'b1;
      end
   end

   // port-level frame capture
   logic p_clk = 1'b1, p_sel = 1'b1, p_rdy = 1'b1;
   logic [15:0] cap = '0;
   int ncap = 0, tail_rises = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (port_clk && !p_clk) begin
            if (!port_sel_n) begin cap = {cap[14:0], port_data}; ncap++; end
            else tail_rises++;
         end
         if (port_sel_n && !p_sel) begin
            chk(ncap == FW, "R2", "rising edges under select", ncap, FW);
            chk(cap == m_frame, "R2", "captured frame", cap, m_frame);
            ncap = 0;
         end
         if (req_ready && !p_rdy) begin
            chk(tail_rises == 1, "R5", "trailing rising edges", tail_rises, 1);
            tail_rises = 0;
         end
         p_clk = port_clk; p_sel = port_sel_n; p_rdy = req_ready;
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic send(input logic [6:0] a, input logic [8:0] d, input logic nc);
      wait_idle();
      req_valid = 1'b1; req_addr = a; req_data = d; req_nocache = nc;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic peek(input logic [4:0] idx, input logic [8:0] exp, input string tag);
      sweep = 0;
      @(posedge clk);
      shd_raddr = idx;
      @(negedge clk);
      chk(shd_rdata == exp, tag, "shadow entry", shd_rdata, exp);
      sweep = 1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(port_sel_n == 1'b1, "R1", "select", port_sel_n, 1);
      chk(port_clk == 1'b1, "R1", "bit clock", port_clk, 1);
      chk(port_data == 1'b0, "R1", "data", port_data, 0);
      chk(port_dir_wr == 1'b0, "R1", "direction", port_dir_wr, 0);
      chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
      for (int i = 0; i < 32; i++) begin
         shd_raddr = 5'(i);
         #1;
         chk(shd_rdata == 9'd0, "R1", "shadow cleared", shd_rdata, 0);
      end
      shd_raddr = '0;
      @(negedge clk);
      rst_n = 1'b1;

      send(7'd5, 9'h1A5, 1'b0);
      wait_idle();
      peek(5'd5, 9'h1A5, "R7");

      send(7'd5, 9'h033, 1'b1);
      wait_idle();
      peek(5'd5, 9'h1A5, "R8");

      send(7'h45, 9'h0F0, 1'b0);
      wait_idle();
      peek(5'd5, 9'h1A5, "R9");

      send(7'h1F, 9'h1FF, 1'b0);
      req_valid = 1'b1; req_addr = 7'd7; req_data = 9'h0AA; req_nocache = 1'b0;
      repeat (30) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      peek(5'd7, 9'h000, "R10");
      peek(5'd31, 9'h1FF, "R7");

      send(7'd0, 9'h001, 1'b0);
      send(7'h7F, 9'h100, 1'b0);
      wait_idle();
      peek(5'd0, 9'h001, "R7");
      peek(5'd31, 9'h1FF, "R9");
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule